// File: doc/BRIEF.md
# Half-Duplex Transmit Retry and Completion Status

This block sits beside a half-duplex transmitter. It follows one frame from its launch request to its end and decides, cycle by cycle, whether a collision leads to another attempt or ends the frame. It also decides whether the wait for a quiet medium has gone on too long, and whether the transmit buffer ran dry. When the frame ends, normally or by abort, it presents a 12-bit completion status word with a one-cycle valid strobe. The word holds the outcome flags and the collision count.

A `byte_tick_i` strobe marks one byte time. While the frame is deferring, the strobe measures waiting time. While the frame is transmitting, each strobe is one byte on the wire, preamble and start delimiter included. Backoff timing, data movement, CRC and the line interface stay with the surrounding logic. That logic reacts to `retry_o` by launching the next attempt, and to `abort_o` by dropping the frame.

Status word layout: bit 0 excessive collisions, bit 1 late collision, bit 2 underflow, bit 3 excessive deferral, bit 4 deferred, bit 5 no carrier, bit 6 loss of carrier, bit 7 VLAN frame, bits 11:8 collision count.

Top module: `tx_retry_status`

## Requirements
- R1: After reset, `retry_o`, `abort_o`, `suspend_o`, `underflow_o` and `stat_valid_o` are low and `stat_o` is zero.
- R2: A frame launched with `start_i` while idle clears every status bit. The frame completes when `eof_i` is seen during transmission. One cycle later `stat_valid_o` pulses for exactly one cycle with `abort_o` low. Every abort also pulses `stat_valid_o` in the same cycle.
- R3: If `crs_i` is high in the launch cycle, the frame waits until `crs_i` is low and reports bit 4 (deferred) set. Otherwise bit 4 reads 0.
- R4: A collision seen after fewer than 64 byte ticks of the current attempt, with retry enabled and fewer than 15 earlier collisions, pulses `retry_o` for one cycle in the following cycle. It also increments the count in bits 11:8 and restarts the byte count at zero. A collision after 63 ticks still retries.
- R5: A collision once 64 byte ticks of the attempt have passed sets bit 1 (late collision) and aborts the frame, with no `retry_o`.
- R6: With `retry_dis_i` high, the first collision sets bit 0 (excessive collisions) and aborts, with no `retry_o`.
- R7: With retry enabled, the 16th collision of one frame sets bit 0 and aborts. Whenever bit 0 is set, bits 11:8 read zero.
- R8: With `defer_chk_en_i` high, the 3037th byte tick spent deferring under carrier sets bit 3 (excessive deferral) and aborts the frame; 3036 ticks do not. With `defer_chk_en_i` low, no deferral time aborts the frame.
- R9: `fifo_empty_i` during transmission without `eof_i` aborts the frame with bit 2 (underflow) set. In the same cycle as the status strobe, `underflow_o` pulses. `suspend_o` then stays high until the next `start_i`. Bit 1 reads zero whenever bit 2 is set.
- R10: At normal completion, bit 5 (no carrier) is set if `crs_i` was never high during the final attempt. Bit 6 (loss of carrier) is set if `crs_i` fell after having been high while transmitting.
- R11: Bit 7 holds the value of `vlan_i` sampled at launch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| retry_dis_i | input | 1 | High: no retries, first collision is fatal |
| defer_chk_en_i | input | 1 | High: enforce the deferral timeout |
| start_i | input | 1 | Launch a new frame (accepted when idle) |
| vlan_i | input | 1 | Frame carries a VLAN tag, sampled at launch |
| byte_tick_i | input | 1 | One byte time elapsed |
| crs_i | input | 1 | Carrier sense |
| col_i | input | 1 | Collision detect |
| fifo_empty_i | input | 1 | Transmit buffer empty |
| eof_i | input | 1 | Last byte of the frame sent |
| retry_o | output | 1 | One-cycle request to start another attempt |
| abort_o | output | 1 | One-cycle abort strobe for the current frame |
| suspend_o | output | 1 | Transmit path suspended after underflow |
| underflow_o | output | 1 | One-cycle underflow strobe |
| stat_valid_o | output | 1 | One-cycle strobe, `stat_o` holds the frame result |
| stat_o | output | 12 | Completion status word |

## Verification
Two cases are hard to reach from the ports. The first is the sixteenth collision of one frame, which needs fifteen full retry cycles driven back to back, each confirmed by its own `retry_o` pulse before the next attempt starts. The second is the deferral limit, which needs more than three thousand byte ticks under steady carrier. The bench stops one tick short of that limit to show that no strobe appears, then adds one more tick. The 63-versus-64 tick edge of the late-collision window is reached by counting ticks exactly within one attempt, after a retry has cleared the counter.

// File: rtl/tx_retry_pkg.sv
package tx_retry_pkg;

  localparam int unsigned MAX_ATTEMPTS = 16;
  localparam int unsigned CNT_W        = $clog2(MAX_ATTEMPTS);

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_DEFER,
    ST_XMIT
  } tx_state_e;

  typedef struct packed {
    logic [CNT_W-1:0] col_cnt;      // [11:8]
    logic             vlan;         // [7]
    logic             loss_carrier; // [6]
    logic             no_carrier;   // [5]
    logic             deferred;     // [4]
    logic             exc_defer;    // [3]
    logic             underflow;    // [2]
    logic             late_col;     // [1]
    logic             exc_col;      // [0]
  } tx_stat_t;

  localparam int unsigned STAT_W = $bits(tx_stat_t);

endpackage

// File: rtl/tx_byte_window.sv
module tx_byte_window #(
  parameter int unsigned LATE_BYTES = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic tick_i,
  output logic late_o
);
  localparam int unsigned W = $clog2(LATE_BYTES + 1);
  localparam logic [W-1:0] LAST = W'(LATE_BYTES);

  logic [W-1:0] cnt_q;

  // saturates at the boundary, nothing past it matters
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (clr_i)                   cnt_q <= '0;
    else if (tick_i && cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  assign late_o = (cnt_q == LAST);
endmodule

// File: rtl/tx_defer_timer.sv
module tx_defer_timer #(
  parameter int unsigned LIMIT = 3036
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic run_i,
  input  logic tick_i,
  input  logic en_i,
  output logic expired_o
);
  localparam int unsigned W = $clog2(LIMIT + 1);
  localparam logic [W-1:0] LAST = W'(LIMIT);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              cnt_q <= '0;
    else if (clr_i)                           cnt_q <= '0;
    else if (run_i && tick_i && cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  // fires on the first tick beyond the limit
  assign expired_o = en_i & run_i & tick_i & (cnt_q == LAST);
endmodule

// File: rtl/tx_carrier_mon.sv
module tx_carrier_mon (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic frame_clr_i,
  input  logic attempt_clr_i,
  input  logic active_i,
  input  logic crs_i,
  output logic seen_now_o,
  output logic loss_o
);
  logic seen_q, loss_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q <= 1'b0;
      loss_q <= 1'b0;
    end else if (frame_clr_i) begin
      seen_q <= 1'b0;
      loss_q <= 1'b0;
    end else if (attempt_clr_i) begin
      seen_q <= 1'b0;
    end else if (active_i) begin
      seen_q <= seen_q | crs_i;
      if (seen_q && !crs_i) loss_q <= 1'b1;
    end
  end

  assign seen_now_o = seen_q | crs_i;
  assign loss_o     = loss_q;
endmodule

// File: rtl/tx_retry_status.sv
module tx_retry_status
  import tx_retry_pkg::*;
#(
  parameter int unsigned LATE_BYTES  = 64,
  parameter int unsigned DEFER_LIMIT = 3036
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              retry_dis_i,
  input  logic              defer_chk_en_i,
  input  logic              start_i,
  input  logic              vlan_i,
  input  logic              byte_tick_i,
  input  logic              crs_i,
  input  logic              col_i,
  input  logic              fifo_empty_i,
  input  logic              eof_i,
  output logic              retry_o,
  output logic              abort_o,
  output logic              suspend_o,
  output logic              underflow_o,
  output logic              stat_valid_o,
  output logic [STAT_W-1:0] stat_o
);
  localparam logic [CNT_W-1:0] LAST_RETRY = CNT_W'(MAX_ATTEMPTS - 1);

  tx_state_e        state_q;
  logic [CNT_W-1:0] col_cnt_q;
  logic exc_col_q, late_q, uf_q, xd_q, dfr_q, nc_q, vlan_q;
  logic retry_q, abort_q, valid_q, uf_pulse_q, suspend_q;

  logic in_idle, in_defer, in_xmit;
  logic late_zone, defer_expired, seen_now, loss;
  logic frame_start, col_hit, late_hit, limit_hit, retry_hit;
  logic uf_hit, eof_hit, xd_hit, finish;

  assign in_idle  = (state_q == ST_IDLE);
  assign in_defer = (state_q == ST_DEFER);
  assign in_xmit  = (state_q == ST_XMIT);

  assign frame_start = in_idle & start_i;
  assign col_hit     = in_xmit & col_i;
  assign late_hit    = col_hit & late_zone;
  assign limit_hit   = col_hit & ~late_zone & (retry_dis_i | (col_cnt_q == LAST_RETRY));
  assign retry_hit   = col_hit & ~late_zone & ~limit_hit;
  assign uf_hit      = in_xmit & ~col_i & fifo_empty_i & ~eof_i;
  assign eof_hit     = in_xmit & ~col_i & eof_i;
  assign xd_hit      = in_defer & defer_expired;
  assign finish      = late_hit | limit_hit | uf_hit | eof_hit | xd_hit;

  tx_byte_window #(.LATE_BYTES(LATE_BYTES)) win_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (~in_xmit | retry_hit),
    .tick_i (byte_tick_i),
    .late_o (late_zone)
  );

  tx_defer_timer #(.LIMIT(DEFER_LIMIT)) dly_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (~in_defer),
    .run_i     (crs_i),
    .tick_i    (byte_tick_i),
    .en_i      (defer_chk_en_i),
    .expired_o (defer_expired)
  );

  tx_carrier_mon crs_i_mon (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .frame_clr_i   (frame_start),
    .attempt_clr_i (retry_hit),
    .active_i      (in_xmit),
    .crs_i         (crs_i),
    .seen_now_o    (seen_now),
    .loss_o        (loss)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      col_cnt_q  <= '0;
      exc_col_q  <= 1'b0;
      late_q     <= 1'b0;
      uf_q       <= 1'b0;
      xd_q       <= 1'b0;
      dfr_q      <= 1'b0;
      nc_q       <= 1'b0;
      vlan_q     <= 1'b0;
      retry_q    <= 1'b0;
      abort_q    <= 1'b0;
      valid_q    <= 1'b0;
      uf_pulse_q <= 1'b0;
      suspend_q  <= 1'b0;
    end else begin
      retry_q    <= retry_hit;
      abort_q    <= finish & ~eof_hit;
      valid_q    <= finish;
      uf_pulse_q <= uf_hit;

      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            col_cnt_q <= '0;
            exc_col_q <= 1'b0;
            late_q    <= 1'b0;
            uf_q      <= 1'b0;
            xd_q      <= 1'b0;
            nc_q      <= 1'b0;
            suspend_q <= 1'b0;
            dfr_q     <= crs_i;
            vlan_q    <= vlan_i;
            state_q   <= crs_i ? ST_DEFER : ST_XMIT;
          end
        end
        ST_DEFER: begin
          if (!crs_i) begin
            state_q <= ST_XMIT;
          end else if (xd_hit) begin
            xd_q    <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        ST_XMIT: begin
          // late collision and hard limits win over retry
          if (late_hit) begin
            late_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else if (limit_hit) begin
            exc_col_q <= 1'b1;
            state_q   <= ST_IDLE;
          end else if (retry_hit) begin
            col_cnt_q <= col_cnt_q + 1'b1;
          end else if (uf_hit) begin
            uf_q      <= 1'b1;
            suspend_q <= 1'b1;
            state_q   <= ST_IDLE;
          end else if (eof_hit) begin
            nc_q    <= ~seen_now;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  tx_stat_t stat;
  always_comb begin
    stat.col_cnt      = exc_col_q ? '0 : col_cnt_q;
    stat.vlan         = vlan_q;
    stat.loss_carrier = loss;
    stat.no_carrier   = nc_q;
    stat.deferred     = dfr_q;
    stat.exc_defer    = xd_q;
    stat.underflow    = uf_q;
    stat.late_col     = late_q & ~uf_q;
    stat.exc_col      = exc_col_q;
  end

  assign stat_o       = stat;
  assign retry_o      = retry_q;
  assign abort_o      = abort_q;
  assign stat_valid_o = valid_q;
  assign underflow_o  = uf_pulse_q;
  assign suspend_o    = suspend_q;
endmodule

// File: rtl/tx_retry_status_chk.sv
module tx_retry_status_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        retry_dis_i,
  input logic        retry_o,
  input logic        abort_o,
  input logic        suspend_o,
  input logic        underflow_o,
  input logic        stat_valid_o,
  input logic [11:0] stat_o
);
  // R2
  valid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_valid_o |=> !stat_valid_o);

  // R2
  abort_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |-> stat_valid_o);

  // R4
  retry_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retry_o |=> !retry_o);

  // R4
  retry_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retry_o |-> (stat_o[11:8] == $past(stat_o[11:8]) + 4'd1) && !stat_valid_o);

  // R5
  late_abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_valid_o && stat_o[1]) |-> (abort_o && !retry_o));

  // R6
  retry_dis_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retry_o |-> !$past(retry_dis_i));

  // R7
  exc_cnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_valid_o && stat_o[0]) |-> (stat_o[11:8] == 4'd0 && abort_o));

  // R9
  underflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underflow_o |-> (abort_o && suspend_o && stat_o[2] && !stat_o[1]));
endmodule

bind tx_retry_status tx_retry_status_chk chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .retry_dis_i  (retry_dis_i),
  .retry_o      (retry_o),
  .abort_o      (abort_o),
  .suspend_o    (suspend_o),
  .underflow_o  (underflow_o),
  .stat_valid_o (stat_valid_o),
  .stat_o       (stat_o)
);

// File: tb/tx_retry_status_tb_top.sv
`timescale 1ns/1ps
module tx_retry_status_tb_top;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic retry_dis_i = 1'b0, defer_chk_en_i = 1'b0;
  logic start_i = 1'b0, vlan_i = 1'b0, byte_tick_i = 1'b0;
  logic crs_i = 1'b0, col_i = 1'b0, fifo_empty_i = 1'b0, eof_i = 1'b0;
  logic retry_o, abort_o, suspend_o, underflow_o, stat_valid_o;
  logic [11:0] stat_o;

  int checks = 0;
  int errors = 0;
  logic [12:0] exp_q[$];

  always #2.5 clk_i = ~clk_i;

  tx_retry_status dut_i (
    .clk_i, .rst_ni, .retry_dis_i, .defer_chk_en_i, .start_i, .vlan_i,
    .byte_tick_i, .crs_i, .col_i, .fifo_empty_i, .eof_i,
    .retry_o, .abort_o, .suspend_o, .underflow_o, .stat_valid_o, .stat_o
  );

  task automatic chk(input bit ok, input string req, input logic [12:0] act, input logic [12:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [11:0] mk(input bit xc, input bit late, input bit uf, input bit xd,
                                     input bit dfr, input bit nc, input bit loc, input bit vl,
                                     input int cnt);
    return {cnt[3:0], vl, loc, nc, dfr, xd, uf, late, xc};
  endfunction

  task automatic push(input bit ab, input logic [11:0] st);
    exp_q.push_back({ab, st});
  endtask

  // scoreboard monitor
  always @(posedge clk_i) begin
    #1;
    if (rst_ni && stat_valid_o) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R2 unexpected status", {abort_o, stat_o}, 13'h0);
      end else begin
        logic [12:0] e;
        e = exp_q.pop_front();
        chk({abort_o, stat_o} == e, "R2-status", {abort_o, stat_o}, e);
      end
    end
  end

  task automatic cyc(input bit tk, input bit crs, input bit col, input bit fe,
                     input bit eof, input bit st, input bit vl);
    @(negedge clk_i);
    byte_tick_i = tk; crs_i = crs; col_i = col; fifo_empty_i = fe;
    eof_i = eof; start_i = st; vlan_i = vl;
  endtask

  task automatic ticks(input int n, input bit crs);
    for (int i = 0; i < n; i++) cyc(1'b1, crs, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic launch(input bit crs, input bit vl);
    cyc(1'b0, crs, 1'b0, 1'b0, 1'b0, 1'b1, vl);
  endtask

  task automatic finish_eof(input bit crs);
    cyc(1'b0, crs, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    cyc(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic collide(input bit want_retry, input string req);
    cyc(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    @(posedge clk_i); #1;
    chk(retry_o == want_retry, req, {12'h0, retry_o}, {12'h0, want_retry});
    cyc(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    #1;
    // R1 reset state
    chk({retry_o, abort_o, suspend_o, underflow_o, stat_valid_o} == 5'b0 && stat_o == 12'h0,
        "R1", {1'b0, stat_o}, 13'h0);
    @(negedge clk_i) rst_ni = 1'b1;

    // R2 clean frame, carrier present
    launch(1'b0, 1'b0); ticks(100, 1'b1);
    push(1'b0, mk(0,0,0,0,0,0,0,0,0)); finish_eof(1'b1);

    // R3 R11 R10 deferred, vlan, no carrier
    launch(1'b1, 1'b1); ticks(5, 1'b1); ticks(20, 1'b0);
    push(1'b0, mk(0,0,0,0,1,1,0,1,0)); finish_eof(1'b0);

    // R10 loss of carrier
    launch(1'b0, 1'b0); ticks(10, 1'b1); ticks(10, 1'b0);
    push(1'b0, mk(0,0,0,0,0,0,1,0,0)); finish_eof(1'b0);

    // R4 retries, including one at 63 ticks
    launch(1'b0, 1'b0);
    ticks(10, 1'b1); collide(1'b1, "R4 retry");
    ticks(63, 1'b1); collide(1'b1, "R4 retry at 63 ticks");
    ticks(30, 1'b1); collide(1'b1, "R4 retry");
    ticks(80, 1'b1);
    push(1'b0, mk(0,0,0,0,0,0,0,0,3)); finish_eof(1'b1);

    // R5 late collision after a retry restarted the window
    launch(1'b0, 1'b0);
    ticks(50, 1'b1); collide(1'b1, "R4 retry");
    ticks(64, 1'b1);
    push(1'b1, mk(0,1,0,0,0,0,0,0,1)); collide(1'b0, "R5 no retry after late");
    cyc(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);

    // R6 retry disabled
    retry_dis_i = 1'b1;
    launch(1'b0, 1'b0); ticks(8, 1'b1);
    push(1'b1, mk(1,0,0,0,0,0,0,0,0)); collide(1'b0, "R6 no retry");
    retry_dis_i = 1'b0;

    // R7 sixteen collisions
    launch(1'b0, 1'b1);
    for (int i = 0; i < 15; i++) begin
      ticks(5, 1'b1); collide(1'b1, "R7 retry before limit");
    end
    ticks(5, 1'b1);
    push(1'b1, mk(1,0,0,0,0,0,0,1,0)); collide(1'b0, "R7 16th collision");

    // R8 deferral limit enabled
    defer_chk_en_i = 1'b1;
    launch(1'b1, 1'b0); ticks(3036, 1'b1);
    @(posedge clk_i); #1;
    chk(stat_valid_o == 1'b0 && exp_q.size() == 0, "R8 no abort at 3036", {12'h0, stat_valid_o}, 13'h0);
    push(1'b1, mk(0,0,0,1,1,0,0,0,0)); ticks(1, 1'b1);
    cyc(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);

    // R8 deferral limit disabled
    defer_chk_en_i = 1'b0;
    launch(1'b1, 1'b0); ticks(3100, 1'b1); ticks(2, 1'b0); ticks(10, 1'b1);
    push(1'b0, mk(0,0,0,0,1,0,0,0,0)); finish_eof(1'b1);

    // R9 underflow
    launch(1'b0, 1'b0); ticks(20, 1'b1);
    push(1'b1, mk(0,0,1,0,0,0,0,0,0));
    cyc(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    @(posedge clk_i); #1;
    chk(underflow_o && suspend_o, "R9 strobe", {11'h0, underflow_o, suspend_o}, 13'h3);
    cyc(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    repeat (3) @(posedge clk_i); #1;
    chk(suspend_o && !underflow_o, "R9 suspend held", {11'h0, underflow_o, suspend_o}, 13'h1);
    launch(1'b0, 1'b0);
    @(posedge clk_i); #1;
    chk(!suspend_o, "R9 suspend cleared", {12'h0, suspend_o}, 13'h0);
    ticks(30, 1'b1);
    push(1'b0, mk(0,0,0,0,0,0,0,0,0)); finish_eof(1'b1);

    repeat (5) @(posedge clk_i); #1;
    chk(exp_q.size() == 0, "R2 all results seen", 13'(exp_q.size()), 13'h0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule